// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between the host bus of a partitioned NOR-style flash device and its internal write state machine. Each bus write carries an address and a 16-bit word. When no sequence is open, the low byte of the word is an opcode. The block keeps one read mode per partition, and the top address bits pick the partition. It also runs the multi-write command sequences: a one-time or lock register program, a configuration register load, and a counted write-buffer load that must end in a confirm word. When a sequence completes it emits a single-cycle request pulse, together with a registered address and data word, to the state machine that does the work.

The block also holds the device status byte. Bit 7 mirrors the state machine's ready flag. Bits 6:0 are sticky error flags. Only the state machine, or a malformed sequence detected here, can set them. The host can only clear them.

Top module: `fcui_top`

## Requirements
- R1: After reset every partition is in array mode, error bits 6:0 of `status` are zero, and no request output is high.
- R2: With no sequence open, a write whose low byte is 0xFF, 0x70, 0x90 or 0x98 sets the addressed partition (address bits [ADDR_W-1 -: log2(PART_CNT)]) to mode 0 (array), 1 (status), 2 (identifier) or 3 (query), held in `part_mode[2p+1:2p]`. Other partitions keep their modes.
- R3: With no sequence open, a write whose low byte is not a known opcode changes no partition mode, raises no request and leaves `status` unchanged.
- R4: Opcode 0xC0 followed by a write to the same full address requests a register program, with `op_addr` set to that address and `op_data` set to the second word. The request is `req_lock_pgm` when address bits 15:0 equal LOCK_OFS (0x0080) and `req_prot_pgm` otherwise. The addressed partition enters status mode on the first write.
- R5: If the second write of an 0xC0 sequence uses a different address, no request is raised, the sequence ends, and status bits 5 and 4 are set to flag a command-sequence error.
- R6: Opcode 0x60 followed by low byte 0x03 raises `req_cfg_pgm`. `op_addr` is the second write's address and `op_data` is that address's bits 15:0. Any other second low byte raises a command-sequence error instead.
- R7: Opcode 0xE8 puts the partition in status mode. The next write, at the same address, gives a count n from 0 to 31. Each of the following n+1 writes raises `req_buf_word` with that write's address and data and is never decoded as an opcode. A final low byte of 0xD0 then raises `req_buf_pgm`, with `op_addr` set to the 0xE8 address and `op_data` set to n.
- R8: A count above 31, or a count written at another address, raises a command-sequence error, ends the sequence, and produces no buffer-word request.
- R9: Any low byte other than 0xD0 in the confirm slot raises a command-sequence error and no `req_buf_pgm`.
- R10: A write with low byte 0x50 clears status bits 6:0. Bits set through `wsm_err` stay set until cleared, and a set in the same cycle as a clear wins.
- R11: `status[7]` equals `wsm_ready` in the same cycle.
- R12: Each request is a single-cycle pulse in the cycle after the write that completes it, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | ADDR_W | Write address; top bits select the partition |
| bus_wdata | input | 16 | Write data / opcode in low byte |
| wsm_ready | input | 1 | Write state machine idle flag |
| wsm_err | input | 7 | Error bits raised by the write state machine |
| part_mode | output | 2*PART_CNT | Read mode per partition, two bits each |
| req_prot_pgm | output | 1 | One-time register program request |
| req_lock_pgm | output | 1 | Lock register program request |
| req_cfg_pgm | output | 1 | Configuration register load request |
| req_buf_word | output | 1 | Write-buffer word load request |
| req_buf_pgm | output | 1 | Buffered array program start request |
| op_addr | output | ADDR_W | Address that goes with the request |
| op_data | output | 16 | Data that goes with the request |
| status | output | 8 | Ready flag and sticky error bits |

## Verification
The bench builds the block with ADDR_W=20, PART_CNT=4 and BUF_WORDS=32. Four partitions are enough to hold array, status, identifier and query modes at the same time, which shows that each mode write lands only in its own slot. The full 32-entry buffer lets a count of 31 load 32 words and lets a count of 32 be rejected, which covers both edges of the limit. A scoreboard queue compares every request pulse with what the driver predicted, so any unexpected pulse after an aborted sequence is also caught.

// File: rtl/fcui_pkg.sv
package fcui_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        C_NONE,
        C_MODE,
        C_CLR,
        C_PREG,
        C_CFG,
        C_BUF
    } cmd_cls_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREG,
        S_CFG,
        S_COUNT,
        S_DATA,
        S_CONF
    } seq_state_t;

    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_CLR      = 8'h50;
    localparam logic [7:0] OP_PREG     = 8'hC0;
    localparam logic [7:0] OP_CFG      = 8'h60;
    localparam logic [7:0] OP_CFG_OK   = 8'h03;
    localparam logic [7:0] OP_BUF      = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;

    localparam int         ERR_W       = 7;
    localparam logic [6:0] SEQ_ERR_SET = 7'b011_0000;

endpackage

// File: rtl/fcui_decode.sv
module fcui_decode
    import fcui_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_cls_t   cls,
    output rmode_t     mode
);

    always_comb begin
        cls  = C_NONE;
        mode = RM_ARRAY;
        unique case (opcode)
            OP_ARRAY:  begin cls = C_MODE; mode = RM_ARRAY;  end
            OP_STATUS: begin cls = C_MODE; mode = RM_STATUS; end
            OP_IDENT:  begin cls = C_MODE; mode = RM_IDENT;  end
            OP_QUERY:  begin cls = C_MODE; mode = RM_QUERY;  end
            OP_CLR:    cls = C_CLR;
            OP_PREG:   cls = C_PREG;
            OP_CFG:    cls = C_CFG;
            OP_BUF:    cls = C_BUF;
            default:   cls = C_NONE;
        endcase
    end

endmodule

// File: rtl/fcui_seq.sv
module fcui_seq
    import fcui_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          PART_CNT  = 8,
    parameter int          BUF_WORDS = 32,
    parameter logic [15:0] LOCK_OFS  = 16'h0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [15:0]         wdata,
    output logic                mode_we,
    output logic [$clog2(PART_CNT)-1:0] mode_part,
    output rmode_t              mode_val,
    output logic                clr_err,
    output logic                seq_err,
    output logic                req_prot,
    output logic                req_lock,
    output logic                req_cfg,
    output logic                req_word,
    output logic                req_buf,
    output logic [ADDR_W-1:0]   op_addr,
    output logic [15:0]         op_data
);

    localparam int PART_W = $clog2(PART_CNT);
    localparam int CNT_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam logic [15:0]  CNT_MAX  = 16'(BUF_WORDS - 1);
    localparam logic [CNT_W:0] WORD_LIM = (CNT_W + 1)'(BUF_WORDS);

    typedef struct packed {
        seq_state_t          st;
        logic [ADDR_W-1:0]   tgt;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    left;
        logic                r_prot;
        logic                r_lock;
        logic                r_cfg;
        logic                r_word;
        logic                r_buf;
        logic [ADDR_W-1:0]   oa;
        logic [15:0]         od;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    cmd_cls_t dec_cls;
    rmode_t   dec_mode;

    fcui_decode u_dec (
        .opcode (wdata[7:0]),
        .cls    (dec_cls),
        .mode   (dec_mode)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.r_prot = 1'b0;
        seq_d.r_lock = 1'b0;
        seq_d.r_cfg  = 1'b0;
        seq_d.r_word = 1'b0;
        seq_d.r_buf  = 1'b0;
        mode_we      = 1'b0;
        mode_part    = addr[ADDR_W-1 -: PART_W];
        mode_val     = RM_ARRAY;
        clr_err      = 1'b0;
        seq_err      = 1'b0;
        if (we) begin
            unique case (seq_q.st)
                S_IDLE: begin
                    unique case (dec_cls)
                        C_MODE: begin
                            mode_we  = 1'b1;
                            mode_val = dec_mode;
                        end
                        C_CLR: clr_err = 1'b1;
                        C_PREG: begin
                            mode_we   = 1'b1;
                            mode_val  = RM_STATUS;
                            seq_d.st  = S_PREG;
                            seq_d.tgt = addr;
                        end
                        C_CFG: seq_d.st = S_CFG;
                        C_BUF: begin
                            mode_we   = 1'b1;
                            mode_val  = RM_STATUS;
                            seq_d.st  = S_COUNT;
                            seq_d.tgt = addr;
                        end
                        default: ;
                    endcase
                end
                S_PREG: begin
                    seq_d.st = S_IDLE;
                    if (addr == seq_q.tgt) begin
                        if (addr[15:0] == LOCK_OFS) seq_d.r_lock = 1'b1;
                        else                        seq_d.r_prot = 1'b1;
                        seq_d.oa = addr;
                        seq_d.od = wdata;
                    end else begin
                        seq_err = 1'b1;
                    end
                end
                S_CFG: begin
                    seq_d.st = S_IDLE;
                    if (wdata[7:0] == OP_CFG_OK) begin
                        seq_d.r_cfg = 1'b1;
                        seq_d.oa    = addr;
                        seq_d.od    = addr[15:0];
                    end else begin
                        seq_err = 1'b1;
                    end
                end
                S_COUNT: begin
                    if ((addr != seq_q.tgt) || (wdata > CNT_MAX)) begin
                        seq_err  = 1'b1;
                        seq_d.st = S_IDLE;
                    end else begin
                        seq_d.cnt  = wdata[CNT_W-1:0];
                        seq_d.left = wdata[CNT_W-1:0];
                        seq_d.st   = S_DATA;
                    end
                end
                S_DATA: begin
                    seq_d.r_word = 1'b1;
                    seq_d.oa     = addr;
                    seq_d.od     = wdata;
                    if (seq_q.left == '0) seq_d.st = S_CONF;
                    else                  seq_d.left = seq_q.left - 1'b1;
                end
                S_CONF: begin
                    seq_d.st = S_IDLE;
                    if (wdata[7:0] == OP_CONFIRM) begin
                        seq_d.r_buf = 1'b1;
                        seq_d.oa    = seq_q.tgt;
                        seq_d.od    = 16'(seq_q.cnt);
                    end else begin
                        seq_err = 1'b1;
                    end
                end
                default: seq_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_prot = seq_q.r_prot;
    assign req_lock = seq_q.r_lock;
    assign req_cfg  = seq_q.r_cfg;
    assign req_word = seq_q.r_word;
    assign req_buf  = seq_q.r_buf;
    assign op_addr  = seq_q.oa;
    assign op_data  = seq_q.od;

    // Checker state: buffer words issued since the sequencer last sat idle
    logic [CNT_W:0] chk_words_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 chk_words_q <= '0;
        else if (seq_q.st == S_IDLE) chk_words_q <= '0;
        else if (req_word)          chk_words_q <= chk_words_q + (CNT_W + 1)'(1);
    end

    a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_prot, req_lock, req_cfg, req_word, req_buf}));

    a_r12_reg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prot || req_lock || req_cfg) |=> !(req_prot || req_lock || req_cfg));

    a_r8_err_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (seq_q.st == S_IDLE));

    a_r7_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
        chk_words_q <= WORD_LIM);

    a_r9_buf_needs_words: assert property (@(posedge clk) disable iff (!rst_n)
        req_buf |-> $past(seq_q.st) == S_CONF);

endmodule

// File: rtl/fcui_modes.sv
module fcui_modes
    import fcui_pkg::*;
#(
    parameter int PART_CNT = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(PART_CNT)-1:0] wr_part,
    input  rmode_t                      wr_val,
    output logic [2*PART_CNT-1:0]       modes
);

    rmode_t mode_d [PART_CNT];
    rmode_t mode_q [PART_CNT];

    always_comb begin
        for (int p = 0; p < PART_CNT; p++) begin
            mode_d[p] = mode_q[p];
        end
        if (wr_en) mode_d[wr_part] = wr_val;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < PART_CNT; p++) begin
            if (!rst_n) mode_q[p] <= RM_ARRAY;
            else        mode_q[p] <= mode_d[p];
        end
    end

    for (genvar g = 0; g < PART_CNT; g++) begin : g_part
        assign modes[2*g +: 2] = mode_q[g];

        a_r2_other_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_part != g)) |=> $stable(modes[2*g +: 2]));
    end

    a_r3_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(modes));

endmodule

// File: rtl/fcui_status.sv
module fcui_status
    import fcui_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             seq_err,
    input  logic [ERR_W-1:0] wsm_err,
    input  logic             wsm_ready,
    output logic [7:0]       status
);

    typedef struct packed {
        logic [ERR_W-1:0] err;
    } st_reg_t;

    st_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.err = '0;
        st_d.err = st_d.err | wsm_err | (seq_err ? SEQ_ERR_SET : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = {wsm_ready, st_q.err};

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status[6:0] & $past(status[6:0])) == $past(status[6:0])));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (wsm_err == '0) && !seq_err) |=> (status[6:0] == '0));

    a_r5_seq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (status[5] && status[4]));

endmodule

// File: rtl/fcui_top.sv
module fcui_top
    import fcui_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          PART_CNT  = 8,
    parameter int          BUF_WORDS = 32,
    parameter logic [15:0] LOCK_OFS  = 16'h0080
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [15:0]           bus_wdata,
    input  logic                  wsm_ready,
    input  logic [6:0]            wsm_err,
    output logic [2*PART_CNT-1:0] part_mode,
    output logic                  req_prot_pgm,
    output logic                  req_lock_pgm,
    output logic                  req_cfg_pgm,
    output logic                  req_buf_word,
    output logic                  req_buf_pgm,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [15:0]           op_data,
    output logic [7:0]            status
);

    localparam int PART_W = $clog2(PART_CNT);

    logic              mode_we;
    logic [PART_W-1:0] mode_part;
    rmode_t            mode_val;
    logic              clr_err;
    logic              seq_err;

    fcui_seq #(
        .ADDR_W    (ADDR_W),
        .PART_CNT  (PART_CNT),
        .BUF_WORDS (BUF_WORDS),
        .LOCK_OFS  (LOCK_OFS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .mode_we   (mode_we),
        .mode_part (mode_part),
        .mode_val  (mode_val),
        .clr_err   (clr_err),
        .seq_err   (seq_err),
        .req_prot  (req_prot_pgm),
        .req_lock  (req_lock_pgm),
        .req_cfg   (req_cfg_pgm),
        .req_word  (req_buf_word),
        .req_buf   (req_buf_pgm),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    fcui_modes #(
        .PART_CNT (PART_CNT)
    ) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_part (mode_part),
        .wr_val  (mode_val),
        .modes   (part_mode)
    );

    fcui_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_err),
        .seq_err   (seq_err),
        .wsm_err   (wsm_err),
        .wsm_ready (wsm_ready),
        .status    (status)
    );

endmodule

// File: tb/tb_fcui_top.sv
module tb_fcui_top;

    localparam int AW = 20;
    localparam int PC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          wsm_ready = 1'b1;
    logic [6:0]    wsm_err = '0;
    logic [2*PC-1:0] part_mode;
    logic          req_prot_pgm, req_lock_pgm, req_cfg_pgm, req_buf_word, req_buf_pgm;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [7:0]    status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fcui_top #(
        .ADDR_W    (AW),
        .PART_CNT  (PC),
        .BUF_WORDS (32),
        .LOCK_OFS  (16'h0080)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .wsm_ready    (wsm_ready),
        .wsm_err      (wsm_err),
        .part_mode    (part_mode),
        .req_prot_pgm (req_prot_pgm),
        .req_lock_pgm (req_lock_pgm),
        .req_cfg_pgm  (req_cfg_pgm),
        .req_buf_word (req_buf_word),
        .req_buf_pgm  (req_buf_pgm),
        .op_addr      (op_addr),
        .op_data      (op_data),
        .status       (status)
    );

    // kinds: 1 prot, 2 lock, 3 cfg, 4 buffer word, 5 buffer program
    typedef struct {
        int          kind;
        logic [AW-1:0] a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t expq[$];

    function automatic logic [AW-1:0] pa(int p, logic [17:0] off);
        logic [1:0] pb;
        pb = 2'(p);
        return {pb, off};
    endfunction

    task automatic push(int kind, logic [AW-1:0] a, logic [15:0] d, string tag);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_mode(int p, logic [1:0] exp, string tag);
        chk(tag, 16'(part_mode[2*p +: 2]), 16'(exp));
    endtask

    // Monitor: pops expectations as request pulses appear
    int mon_kind;
    int mon_n;
    always @(negedge clk) begin
        if (rst_n) begin
            mon_n = int'(req_prot_pgm) + int'(req_lock_pgm) + int'(req_cfg_pgm)
                  + int'(req_buf_word) + int'(req_buf_pgm);
            mon_kind = req_prot_pgm ? 1 : req_lock_pgm ? 2 : req_cfg_pgm ? 3 :
                       req_buf_word ? 4 : req_buf_pgm ? 5 : 0;
            if (mon_n > 1) begin
                checks++; fails++;
                $display("FAIL R12 concurrent requests actual=%0d expected=1", mon_n);
            end else if (mon_n == 1) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R12 unexpected request actual=kind%0d expected=none", mon_kind);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.kind != mon_kind || e.a !== op_addr || e.d !== op_data) begin
                        fails++;
                        $display("FAIL %s actual=k%0d a=%h d=%h expected=k%0d a=%h d=%h",
                                 e.tag, mon_kind, op_addr, op_data, e.kind, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12 watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        logic [AW-1:0] a_p, a_l, a_c, a_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int p = 0; p < PC; p++) chk_mode(p, 2'd0, "R1 reset mode");
        chk("R1 reset status", 16'(status), 16'h0080);
        chk("R1 no request", 16'({req_prot_pgm, req_lock_pgm, req_cfg_pgm, req_buf_word, req_buf_pgm}), 16'h0);

        // R2 mode writes per partition
        wr(pa(1, 18'h00010), 16'h0070);
        wr(pa(2, 18'h00020), 16'h0090);
        wr(pa(3, 18'h00030), 16'h0098);
        chk_mode(0, 2'd0, "R2 p0 array");
        chk_mode(1, 2'd1, "R2 p1 status");
        chk_mode(2, 2'd2, "R2 p2 ident");
        chk_mode(3, 2'd3, "R2 p3 query");
        wr(pa(1, 18'h00000), 16'h00FF);
        chk_mode(1, 2'd0, "R2 p1 back to array");
        chk_mode(2, 2'd2, "R2 p2 untouched");

        // R3 unknown opcode ignored
        wr(pa(2, 18'h00040), 16'h0012);
        wr(pa(3, 18'h00040), 16'h00D5);
        chk_mode(2, 2'd2, "R3 p2 unchanged");
        chk_mode(3, 2'd3, "R3 p3 unchanged");
        chk("R3 status unchanged", 16'(status), 16'h0080);

        // R4 protection and lock register programs
        a_p = pa(0, 18'h00100);
        wr(a_p, 16'h00C0);
        chk_mode(0, 2'd1, "R4 partition to status");
        push(1, a_p, 16'hBEEF, "R4 prot");
        wr(a_p, 16'hBEEF);
        a_l = pa(3, 18'h00080);
        wr(a_l, 16'h00C0);
        push(2, a_l, 16'h0002, "R4 lock");
        wr(a_l, 16'h0002);
        chk("R4 status clean", 16'(status), 16'h0080);

        // R5 address mismatch
        wr(a_p, 16'h00C0);
        wr(a_p + 1, 16'h1234);
        chk("R5 seq error", 16'(status), 16'h00B0);
        wr(a_p, 16'h0050);
        chk("R10 clear", 16'(status), 16'h0080);

        // R6 configuration register
        a_c = pa(2, 18'h04123);
        push(3, a_c, 16'h4123, "R6 cfg");
        wr(a_c, 16'h0060);
        wr(a_c, 16'h0003);
        chk_mode(2, 2'd2, "R6 mode kept");
        wr(a_c, 16'h0060);
        wr(a_c, 16'h0033);
        chk("R6 bad confirm error", 16'(status), 16'h00B0);
        wr(a_c, 16'h0050);

        // R7 buffered program, three words, data that look like opcodes
        a_b = pa(1, 18'h00200);
        wr(a_b, 16'h00E8);
        chk_mode(1, 2'd1, "R7 partition to status");
        wr(a_b, 16'd2);
        push(4, a_b, 16'h0070, "R7 word0");
        wr(a_b, 16'h0070);
        push(4, a_b + 1, 16'h00FF, "R7 word1");
        wr(a_b + 1, 16'h00FF);
        push(4, a_b + 2, 16'h1234, "R7 word2");
        wr(a_b + 2, 16'h1234);
        chk_mode(1, 2'd1, "R7 data not decoded");
        push(5, a_b, 16'd2, "R7 confirm");
        wr(a_b, 16'h00D0);
        chk("R7 status clean", 16'(status), 16'h0080);

        // R7 boundary: count 31 loads 32 words
        wr(a_b, 16'h00E8);
        wr(a_b, 16'd31);
        for (int i = 0; i < 32; i++) begin
            push(4, a_b + AW'(i), 16'(i * 3 + 1), "R7 full word");
            wr(a_b + AW'(i), 16'(i * 3 + 1));
        end
        push(5, a_b, 16'd31, "R7 full confirm");
        wr(a_b, 16'h00D0);

        // R8 count too large
        wr(a_b, 16'h00E8);
        wr(a_b, 16'd32);
        chk("R8 count error", 16'(status), 16'h00B0);
        wr(a_b, 16'hAAAA);
        wr(a_b, 16'h0050);
        // R8 count at other address
        wr(a_b, 16'h00E8);
        wr(a_b + 4, 16'd1);
        chk("R8 count addr error", 16'(status), 16'h00B0);
        wr(a_b, 16'h0050);

        // R9 wrong confirm
        wr(a_b, 16'h00E8);
        wr(a_b, 16'd0);
        push(4, a_b, 16'h5555, "R9 word");
        wr(a_b, 16'h5555);
        wr(a_b, 16'h00D1);
        chk("R9 confirm error", 16'(status), 16'h00B0);
        wr(a_b, 16'h0050);
        chk("R9 cleared", 16'(status), 16'h0080);

        // R10 sticky set and set-wins-over-clear
        @(negedge clk);
        wsm_err = 7'h01;
        @(negedge clk);
        wsm_err = 7'h00;
        repeat (2) @(negedge clk);
        chk("R10 sticky", 16'(status), 16'h0081);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a_b; bus_wdata = 16'h0050; wsm_err = 7'h04;
        @(negedge clk);
        bus_we = 1'b0; wsm_err = 7'h00;
        chk("R10 set wins", 16'(status), 16'h0084);

        // R11 ready mirror
        wsm_ready = 1'b0;
        #1;
        chk("R11 not ready", 16'(status[7]), 16'h0);
        wsm_ready = 1'b1;
        #1;
        chk("R11 ready", 16'(status[7]), 16'h1);

        repeat (3) @(negedge clk);
        chk("R12 all expected requests seen", 16'(expq.size()), 16'h0);
        done = 1;
        finish_run();
    end

endmodule